// File: doc/BRIEF.md
# UART Receive FIFO Overrun Controller

This block stands between the character output of a UART receiver and the receive data FIFO that software reads. Each character the receiver delivers goes into the FIFO when there is room for it. A character that finds no room sets a sticky overrun flag and is dropped. While overrun is pending, the block stores nothing more, so software always knows exactly where data went missing. Software recovers in two steps. It first drains the FIFO, either by reading it or by flushing it. It then reads the status while overrun is set and follows that with a read of the data port. If that final data read finds the FIFO empty, a sticky underflow flag is raised. The underflow flag has its own interrupt enable, so software can mask it during this recovery.

In LIN break-detect mode, the receiver marks break characters. A break sets a pending-break flag and is stored as a zero byte, so software can inspect it. If the pending-break flag has not been cleared when the next data character arrives, overrun is forced whatever the FIFO fill level. The FIFO depth is a parameter, and the FIFO fill state is visible on outputs.

Top module: `uart_rx_ovr_ctrl`

## Requirements
- R1: With overrun clear and room in the FIFO, each valid character is stored. Characters leave in arrival order, and each read of the data port exposes the next one. `count_o`, `empty_o` and `full_o` track the fill level, from 0 up to DEPTH (8 by default).
- R2: A character that arrives while the FIFO is full, with no data read in the same cycle, is dropped. It sets `ovr_o` on the following cycle.
- R3: While `ovr_o` is set, no arriving character is stored, even if space has been freed. `count_o` never rises while overrun is set.
- R4: A flush pulse empties the FIFO by the next cycle. A character that arrives in the same cycle as a flush is dropped and does not set overrun.
- R5: `ovr_o` is cleared only by a data-port read that follows a status read made while overrun was set. A data read without that earlier status read leaves `ovr_o` set. The clearing read still pops the head entry if the FIFO is not empty.
- R6: A data-port read while the FIFO is empty sets `udf_o`. This flag stays set until a write-1 clear pulse. `udf_irq_o` equals `udf_o` gated by its enable input.
- R7: With break detection enabled, a break character sets `brk_flag_o`, which holds until a clear pulse. If there is room, the break is stored as byte 0x00, whatever the data bits carry.
- R8: With break detection enabled and `brk_flag_o` set, the next data character (not a break) sets `ovr_o` and is dropped, even when the FIFO is empty.
- R9: If `brk_flag_o` is cleared before the next data character arrives, that character is stored normally.
- R10: `rdr_irq_o` is high exactly when `count_o` is non-zero.
- R11: With break detection disabled, a break character is stored as 0x00 and sets no break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | Receiver presents a character this cycle |
| char_data_i | input | DATA_W | Received character bits |
| char_brk_i | input | 1 | Presented character is a break |
| brk_det_en_i | input | 1 | LIN break-detect mode enable |
| flush_i | input | 1 | Empty the FIFO |
| stat_rd_i | input | 1 | Software status read strobe |
| data_rd_i | input | 1 | Software data-port read strobe |
| brk_clr_i | input | 1 | Write-1 clear of the break flag |
| udf_clr_i | input | 1 | Write-1 clear of the underflow flag |
| udf_ie_i | input | 1 | Underflow interrupt enable |
| rd_data_o | output | DATA_W | FIFO head entry |
| count_o | output | CNT_W | Stored entries |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| ovr_o | output | 1 | Overrun flag |
| udf_o | output | 1 | Underflow flag |
| brk_flag_o | output | 1 | Break pending flag |
| rdr_irq_o | output | 1 | Receive data ready interrupt |
| udf_irq_o | output | 1 | Underflow interrupt |

## Verification
The assertions check four things on every cycle. The FIFO is never pushed while full without a matching pop, and never popped while empty. The fill count never rises while overrun is held. Overrun only falls after a data read, and it is forced whenever a data character meets a pending break. Underflow always follows an empty read, and a flush always leaves the FIFO empty. Only the bench scenarios can show the rest: that the stored bytes come out in order, that break characters are stored as zero, that a data read without a prior status read does not clear overrun, that a flush followed by the clear sequence raises underflow, and that clearing the break flag in time restores normal storage.

// File: rtl/uart_rx_ovr_pkg.sv
package uart_rx_ovr_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_STORE = 2'd1,
    ACT_DROP  = 2'd2,
    ACT_OVR   = 2'd3
  } wr_act_e;
endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> !full_o);
  assert_no_empty_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_flush_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rx_wr_arbiter.sv
module rx_wr_arbiter
  import uart_rx_ovr_pkg::*;
(
  input  logic    char_valid_i,
  input  logic    char_brk_i,
  input  logic    brk_en_i,
  input  logic    brk_pend_i,
  input  logic    ovr_i,
  input  logic    flush_i,
  input  logic    room_i,
  output wr_act_e act_o,
  output logic    brk_set_o,
  output logic    store_zero_o
);
  always_comb begin
    act_o = ACT_IDLE;
    if (char_valid_i) begin
      if (flush_i)                       act_o = ACT_DROP;
      else if (ovr_i)                    act_o = ACT_DROP;
      else if (brk_en_i && char_brk_i)   act_o = room_i ? ACT_STORE : ACT_OVR;
      else if (brk_en_i && brk_pend_i)   act_o = ACT_OVR;  // forced, fill-independent
      else                               act_o = room_i ? ACT_STORE : ACT_OVR;
    end
  end

  assign brk_set_o    = char_valid_i && char_brk_i && brk_en_i;
  assign store_zero_o = char_brk_i;
endmodule

// File: rtl/rx_brk_track.sv
module rx_brk_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // new break wins over clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_brk_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
endmodule

// File: rtl/rx_ovr_seq.sv
module rx_ovr_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovr_set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  input  logic empty_i,
  input  logic udf_clr_i,
  output logic ovr_o,
  output logic udf_o
);
  logic ovr_q, armed_q, udf_q, ovr_clr;

  assign ovr_clr = armed_q && data_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      if (ovr_clr)        ovr_q <= 1'b0;
      else if (ovr_set_i) ovr_q <= 1'b1;

      // status seen while overrun pending arms the data-read clear
      if (ovr_clr || !ovr_q) armed_q <= 1'b0;
      else if (stat_rd_i)    armed_q <= 1'b1;

      if (data_rd_i && empty_i) udf_q <= 1'b1;
      else if (udf_clr_i)       udf_q <= 1'b0;
    end
  end

  assign ovr_o = ovr_q;
  assign udf_o = udf_q;

  assert_ovr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !data_rd_i |=> ovr_o);
  assert_ovr_clr_by_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_o) |-> $past(data_rd_i));
  assert_udf_on_empty_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && empty_i |=> udf_o);
endmodule

// File: rtl/uart_rx_ovr_ctrl.sv
module uart_rx_ovr_ctrl
  import uart_rx_ovr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_brk_i,
  input  logic              brk_det_en_i,
  input  logic              flush_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              brk_clr_i,
  input  logic              udf_clr_i,
  input  logic              udf_ie_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              udf_o,
  output logic              brk_flag_o,
  output logic              rdr_irq_o,
  output logic              udf_irq_o
);
  wr_act_e           act;
  logic              brk_set, store_zero, pop, push, room;
  logic [DATA_W-1:0] push_data;

  assign pop       = data_rd_i && !empty_o && !flush_i;
  assign room      = !full_o || pop;
  assign push      = (act == ACT_STORE);
  assign push_data = store_zero ? '0 : char_data_i;

  rx_wr_arbiter u_arb (
    .char_valid_i (char_valid_i),
    .char_brk_i   (char_brk_i),
    .brk_en_i     (brk_det_en_i),
    .brk_pend_i   (brk_flag_o),
    .ovr_i        (ovr_o),
    .flush_i      (flush_i),
    .room_i       (room),
    .act_o        (act),
    .brk_set_o    (brk_set),
    .store_zero_o (store_zero)
  );

  rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .flush_i     (flush_i),
    .head_o      (rd_data_o),
    .count_o     (count_o),
    .empty_o     (empty_o),
    .full_o      (full_o)
  );

  rx_brk_track u_brk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (brk_set),
    .clr_i  (brk_clr_i),
    .flag_o (brk_flag_o)
  );

  rx_ovr_seq u_ovr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovr_set_i (act == ACT_OVR),
    .stat_rd_i (stat_rd_i),
    .data_rd_i (data_rd_i),
    .empty_i   (empty_o),
    .udf_clr_i (udf_clr_i),
    .ovr_o     (ovr_o),
    .udf_o     (udf_o)
  );

  assign rdr_irq_o = !empty_o;
  assign udf_irq_o = udf_o && udf_ie_i;

  assert_no_store_in_ovr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> count_o <= $past(count_o));
  assert_brk_forces_ovr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_det_en_i && brk_flag_o && char_valid_i && !char_brk_i && !flush_i |=> ovr_o);
  assert_full_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && full_o && !data_rd_i && !flush_i |=> ovr_o);
endmodule

// File: tb/uart_rx_ovr_ctrl_bench.sv
module uart_rx_ovr_ctrl_bench;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic char_valid = 0, char_brk = 0, brk_en = 0, flush = 0;
  logic stat_rd = 0, data_rd = 0, brk_clr = 0, udf_clr = 0, udf_ie = 0;
  logic [DW-1:0] char_data = '0;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] count;
  logic empty, full, ovr, udf, brk_flag, rdr_irq, udf_irq;

  always #5 clk = ~clk;

  uart_rx_ovr_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) u_uart_rx_ovr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(char_valid), .char_data_i(char_data),
    .char_brk_i(char_brk), .brk_det_en_i(brk_en), .flush_i(flush), .stat_rd_i(stat_rd),
    .data_rd_i(data_rd), .brk_clr_i(brk_clr), .udf_clr_i(udf_clr), .udf_ie_i(udf_ie),
    .rd_data_o(rd_data), .count_o(count), .empty_o(empty), .full_o(full), .ovr_o(ovr),
    .udf_o(udf), .brk_flag_o(brk_flag), .rdr_irq_o(rdr_irq), .udf_irq_o(udf_irq)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  bit m_ovr = 0, m_arm = 0, m_udf = 0, m_brk = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk(count == CW'(exp_q.size()), tag, "count", count, exp_q.size());
    chk(empty == (exp_q.size() == 0), tag, "empty", empty, exp_q.size() == 0);
    chk(full == (exp_q.size() == DEPTH), tag, "full", full, exp_q.size() == DEPTH);
    chk(ovr == m_ovr, tag, "ovr", ovr, m_ovr);
    chk(udf == m_udf, tag, "udf", udf, m_udf);
    chk(udf_irq == (m_udf && udf_ie), tag, "udf_irq", udf_irq, m_udf && udf_ie);
    chk(brk_flag == m_brk, tag, "brk_flag", brk_flag, m_brk);
    chk(rdr_irq == (exp_q.size() != 0), "R10", "rdr_irq", rdr_irq, exp_q.size() != 0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: predicts outcome from requirements, pushes expected bytes
  task automatic send(logic [DW-1:0] d, bit brk, string tag);
    if (brk && brk_en) begin
      m_brk = 1;
      if (!m_ovr) begin
        if (exp_q.size() < DEPTH) exp_q.push_back('0); else m_ovr = 1;
      end
    end else if (!m_ovr) begin
      if (brk_en && m_brk) m_ovr = 1;
      else if (exp_q.size() < DEPTH) exp_q.push_back(brk ? '0 : d);
      else m_ovr = 1;
    end
    char_valid = 1; char_data = d; char_brk = brk;
    step();
    char_valid = 0; char_brk = 0;
    check_state(tag);
  endtask

  // monitor side: compare the head against the scoreboard, then pop
  task automatic rd(string tag);
    if (exp_q.size() != 0) begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk(rd_data == e, tag, "rd_data", rd_data, e);
    end else m_udf = 1;
    if (m_arm) begin m_ovr = 0; m_arm = 0; end
    data_rd = 1;
    step();
    data_rd = 0;
    check_state(tag);
  endtask

  task automatic srd(string tag);
    if (m_ovr) m_arm = 1;
    stat_rd = 1;
    step();
    stat_rd = 0;
    check_state(tag);
  endtask

  task automatic do_flush(string tag);
    exp_q.delete();
    flush = 1;
    step();
    flush = 0;
    check_state(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");

    // R1: in-order storage
    send(8'h11, 0, "R1"); send(8'h22, 0, "R1"); send(8'h33, 0, "R1");
    rd("R1"); rd("R1"); rd("R1");

    // R2: fill then overflow
    for (int i = 0; i < DEPTH; i++) send(8'h40 + 8'(i), 0, "R1");
    send(8'hEE, 0, "R2");
    // R5: data read alone does not clear overrun
    rd("R5");
    // R3: space available but overrun blocks storage
    send(8'h77, 0, "R3");
    srd("R5");
    rd("R5");
    send(8'h55, 0, "R3");
    while (exp_q.size() != 0) rd("R1");

    // R4/R6: flush then clear sequence causes underflow
    for (int i = 0; i < DEPTH; i++) send(8'h60 + 8'(i), 0, "R1");
    send(8'hEF, 0, "R2");
    do_flush("R4");
    udf_ie = 1;
    srd("R5");
    rd("R6");
    step(); check_state("R6");
    udf_clr = 1; m_udf = 0; step(); udf_clr = 0; check_state("R6");

    // R4: flush and arrival in the same cycle
    send(8'h12, 0, "R1");
    flush = 1; char_valid = 1; char_data = 8'h99;
    exp_q.delete();
    step();
    flush = 0; char_valid = 0;
    check_state("R4");

    // R7/R8: LIN break mode
    brk_en = 1;
    send(8'hA5, 1, "R7");
    rd("R7");
    send(8'h31, 0, "R8");
    brk_clr = 1; m_brk = 0; step(); brk_clr = 0; check_state("R7");
    srd("R5");
    rd("R6");
    udf_clr = 1; m_udf = 0; step(); udf_clr = 0; check_state("R6");

    // R9: break cleared in time, next char stored
    send(8'h00, 1, "R7");
    brk_clr = 1; m_brk = 0; step(); brk_clr = 0; check_state("R9");
    send(8'h5A, 0, "R9");
    rd("R9"); rd("R9");

    // R11: detection disabled, break stored as zero, no flag
    brk_en = 0;
    send(8'hC3, 1, "R11");
    send(8'h3C, 0, "R11");
    rd("R11"); rd("R11");

    finish_run();
  end
endmodule